// File: doc/BRIEF.md
# Loop Closure Detector

This block watches a stream of signed loop-current samples and decides whether the subscriber line is closed (off-hook) or open (on-hook). Each sample arrives with a one-clock strobe. It first passes through a first-order low-pass filter whose coefficient is set on a port. The filtered value then feeds a comparator with two thresholds, which gives hysteresis. A debounce state machine follows the comparator and changes the line status only after the comparator has held the opposite level for a programmed number of consecutive samples.

When a ringing burst ends, the driving logic pulses `ring_burst_end`. This opens a mask window of a programmed number of samples. Inside the window the comparator is frozen and any debounce in progress is dropped, so the transient at the end of the burst cannot be reported as a loop closure. Every change of status is also reported by a one-clock interrupt pulse: one output marks the start of a loop closure and another marks its end.

The comparator has two named states: CP_LOW (line looks open) and CP_HIGH (line looks closed). It moves from CP_LOW to CP_HIGH on a close crossing and from CP_HIGH to CP_LOW on an open crossing.

The debounce machine has four named states:
- DB_ON: stable on-hook.
- DB_QUAL_OFF: qualifying a closure.
- DB_OFF: stable off-hook.
- DB_QUAL_ON: qualifying a release.

Its transitions are:
- Qualify-start: DB_ON to DB_QUAL_OFF, or DB_OFF to DB_QUAL_ON.
- Qualify-abort, caused by a comparator reversal: back to the stable state.
- Qualify-done, when the count reaches the interval: on to the opposite stable state.
- Mask-abort: a pending state returns to its stable state.
- With an interval of one, DB_ON goes straight to DB_OFF and DB_OFF goes straight to DB_ON.

The mask machine has two states, MK_IDLE and MK_ACTIVE. It moves from MK_IDLE to MK_ACTIVE on arm and from MK_ACTIVE to MK_IDLE on expire.

Top module: `loop_closure_det`

## Requirements
- R1: On each `sample_stb` the filter state y is updated as y + ((k × (x − y)) >>> 14), where x is `sample_in` and k is the effective coefficient. The shift floors toward minus infinity. Between strobes y does not change.
- R2: A coefficient of 0x4000 makes y equal to the input. A coefficient of 0 freezes y. Any coefficient above 0x4000 acts as 0x4000.
- R3: While the comparator is in CP_LOW, it moves to CP_HIGH on a strobe whose filtered value is strictly greater than `thresh_close`.
- R4: While the comparator is in CP_HIGH, it moves to CP_LOW only on a strobe whose filtered value is strictly less than `thresh_open`. Values between the two thresholds leave it unchanged.
- R5: `loop_closed` changes only after the comparator has shown the opposite level on `debounce_len` consecutive samples. A `debounce_len` of 0 acts as 1.
- R6: A comparator reversal before the count completes returns the debounce machine to its stable state with the count at zero. The next opposite sample starts again from one.
- R7: A `ring_burst_end` pulse with a nonzero `mask_len` opens a window covering the next `mask_len` samples. During the window the comparator holds its level and the debounce count is held at zero. A `mask_len` of 0 opens no window.
- R8: `loop_start_irq` is a one-clock pulse in the cycle where `loop_closed` rises. `loop_end_irq` is a one-clock pulse in the cycle where it falls. The two never fire together.
- R9: Status and interrupt outputs change on the second rising clock edge after the edge that accepts the qualifying sample.
- R10: After reset, `loop_closed`, both interrupts, the filter state and the comparator (CP_LOW) are all zero or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-clock strobe marking a valid sample |
| sample_in | input | DW | Signed loop-current sample |
| lpf_coef | input | KW | Filter coefficient, 0x4000 = unity |
| thresh_close | input | DW | Signed threshold for detecting closure |
| thresh_open | input | DW | Signed threshold for detecting release |
| debounce_len | input | CW | Debounce interval in samples |
| mask_len | input | CW | Mask interval in samples after a ringing burst |
| ring_burst_end | input | 1 | Pulse marking the end of a ringing burst |
| loop_closed | output | 1 | Debounced off-hook status |
| loop_start_irq | output | 1 | One-clock pulse when the loop closes |
| loop_end_irq | output | 1 | One-clock pulse when the loop opens |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 15-bit coefficient and 16-bit interval counters. It drives intervals of 1, 3 and 4 samples, which reaches the immediate, reversal-restart and mask paths within a few dozen samples. Coefficients of 0x4000, 0x2000, 0 and 0x7FFF exercise the unity, halving, frozen and saturated filter cases. With the 0x2000 step the closure is expected to land on the fourth sample, because the floored filter output climbs to 937 against a threshold of 900.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    typedef enum logic [1:0] {
        DB_ON       = 2'd0,
        DB_QUAL_OFF = 2'd1,
        DB_OFF      = 2'd2,
        DB_QUAL_ON  = 2'd3
    } db_state_e;

    typedef enum logic {
        CP_LOW  = 1'b0,
        CP_HIGH = 1'b1
    } cp_state_e;

    typedef enum logic {
        MK_IDLE   = 1'b0,
        MK_ACTIVE = 1'b1
    } mk_state_e;

    localparam int unsigned COEF_FRAC = 14;
    localparam int unsigned COEF_UNITY = 1 << COEF_FRAC;

endpackage

// File: rtl/lcd_lpf.sv
module lcd_lpf #(
    parameter int DW = 16,
    parameter int KW = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [DW-1:0] x_in,
    input  logic        [KW-1:0] coef,
    output logic signed [DW-1:0] y_out,
    output logic                 y_vld
);
    import lcd_pkg::*;

    localparam int DIFW = DW + 1;
    localparam int PW   = DIFW + KW + 1;

    logic signed [DW-1:0]   y_q;
    logic        [KW-1:0]   k_eff;
    logic signed [DIFW-1:0] diff;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   y_sum;

    always_comb begin
        if (int'(coef) > int'(COEF_UNITY)) begin
            k_eff = KW'(COEF_UNITY);
        end else begin
            k_eff = coef;
        end
        diff  = DIFW'(x_in) - DIFW'(y_q);
        prod  = PW'(diff) * PW'($signed({1'b0, k_eff}));
        y_sum = PW'(y_q) + (prod >>> COEF_FRAC);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q   <= '0;
            y_vld <= 1'b0;
        end else begin
            y_vld <= stb;
            if (stb) begin
                y_q <= y_sum[DW-1:0];
            end
        end
    end

    assign y_out = y_q;

    AST_FLT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> (y_sum == PW'($signed(y_sum[DW-1:0])))); // R1

    AST_ZERO_COEF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && coef == '0) |=> $stable(y_q)); // R2

    AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(y_q)); // R1

endmodule

// File: rtl/lcd_hyst_cmp.sv
module lcd_hyst_cmp #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld,
    input  logic signed [DW-1:0] flt,
    input  logic signed [DW-1:0] thr_close,
    input  logic signed [DW-1:0] thr_open,
    input  logic                 hold,
    output logic                 level,
    output logic                 tick
);
    import lcd_pkg::*;

    cp_state_e st_q, st_n;
    logic      upd;

    assign upd = vld & ~hold;

    always_comb begin
        st_n = st_q;
        if (upd) begin
            unique case (st_q)
                CP_LOW:  if (flt > thr_close) st_n = CP_HIGH;
                CP_HIGH: if (flt < thr_open)  st_n = CP_LOW;
                default: st_n = CP_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CP_LOW;
        end else begin
            st_q <= st_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick <= 1'b0;
        end else begin
            tick <= upd;
        end
    end

    assign level = (st_q == CP_HIGH);

    AST_MASK_FREEZES_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(st_q)); // R7

    AST_HYST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && flt <= thr_close && flt >= thr_open) |=> $stable(st_q)); // R4

endmodule

// File: rtl/lcd_mask.sv
module lcd_mask #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [CW-1:0] len,
    input  logic          adv,
    output logic          active
);
    import lcd_pkg::*;

    mk_state_e     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (arm) begin
            if (len != '0) begin
                st_n  = MK_ACTIVE;
                cnt_n = len;
            end
        end else begin
            unique case (st_q)
                MK_IDLE: begin
                    cnt_n = '0;
                end
                MK_ACTIVE: begin
                    if (adv) begin
                        cnt_n = cnt_q - CW'(1);
                        if (cnt_q == CW'(1)) begin
                            st_n = MK_IDLE;
                        end
                    end
                end
                default: st_n = MK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= MK_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign active = (st_q == MK_ACTIVE);

    AST_MASK_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/lcd_debounce.sv
module lcd_debounce #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          level,
    input  logic [CW-1:0] len,
    input  logic          masked,
    output logic          closed,
    output logic          irq_start,
    output logic          irq_end
);
    import lcd_pkg::*;

    db_state_e     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] len_eff;
    logic [CW-1:0] cnt_inc;
    logic          closed_n;

    assign len_eff = (len == '0) ? CW'(1) : len;
    assign cnt_inc = cnt_q + CW'(1);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (masked) begin
            cnt_n = '0;
            unique case (st_q)
                DB_QUAL_OFF: st_n = DB_ON;
                DB_QUAL_ON:  st_n = DB_OFF;
                default:     st_n = st_q;
            endcase
        end else if (tick) begin
            unique case (st_q)
                DB_ON: begin
                    if (level) begin
                        if (len_eff == CW'(1)) begin
                            st_n  = DB_OFF;
                            cnt_n = '0;
                        end else begin
                            st_n  = DB_QUAL_OFF;
                            cnt_n = CW'(1);
                        end
                    end
                end
                DB_QUAL_OFF: begin
                    if (!level) begin
                        st_n  = DB_ON;
                        cnt_n = '0;
                    end else if (cnt_inc >= len_eff) begin
                        st_n  = DB_OFF;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                DB_OFF: begin
                    if (!level) begin
                        if (len_eff == CW'(1)) begin
                            st_n  = DB_ON;
                            cnt_n = '0;
                        end else begin
                            st_n  = DB_QUAL_ON;
                            cnt_n = CW'(1);
                        end
                    end
                end
                DB_QUAL_ON: begin
                    if (level) begin
                        st_n  = DB_OFF;
                        cnt_n = '0;
                    end else if (cnt_inc >= len_eff) begin
                        st_n  = DB_ON;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                default: begin
                    st_n  = DB_ON;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_ON;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    assign closed_n = (st_n == DB_OFF) || (st_n == DB_QUAL_ON);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            closed    <= 1'b0;
            irq_start <= 1'b0;
            irq_end   <= 1'b0;
        end else begin
            closed    <= closed_n;
            irq_start <= closed_n & ~closed;
            irq_end   <= ~closed_n & closed;
        end
    end

    AST_DBNC_CLEARED_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        masked |=> (cnt_q == '0)); // R7

    AST_REVERSAL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !masked && st_q == DB_QUAL_OFF && !level) |=> (cnt_q == '0)); // R6

    AST_COUNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DB_QUAL_OFF || st_q == DB_QUAL_ON) |-> (cnt_q < len_eff || len != $past(len))); // R5

endmodule

// File: rtl/loop_closure_det.sv
module loop_closure_det #(
    parameter int DW = 16,
    parameter int KW = 15,
    parameter int CW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic signed [DW-1:0] sample_in,
    input  logic        [KW-1:0] lpf_coef,
    input  logic signed [DW-1:0] thresh_close,
    input  logic signed [DW-1:0] thresh_open,
    input  logic        [CW-1:0] debounce_len,
    input  logic        [CW-1:0] mask_len,
    input  logic                 ring_burst_end,
    output logic                 loop_closed,
    output logic                 loop_start_irq,
    output logic                 loop_end_irq
);

    logic signed [DW-1:0] flt;
    logic                 flt_vld;
    logic                 mask_on;
    logic                 cmp_level;
    logic                 cmp_tick;

    lcd_lpf #(.DW(DW), .KW(KW)) u_lpf (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (sample_stb),
        .x_in  (sample_in),
        .coef  (lpf_coef),
        .y_out (flt),
        .y_vld (flt_vld)
    );

    lcd_mask #(.CW(CW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (ring_burst_end),
        .len    (mask_len),
        .adv    (flt_vld),
        .active (mask_on)
    );

    lcd_hyst_cmp #(.DW(DW)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld       (flt_vld),
        .flt       (flt),
        .thr_close (thresh_close),
        .thr_open  (thresh_open),
        .hold      (mask_on),
        .level     (cmp_level),
        .tick      (cmp_tick)
    );

    lcd_debounce #(.CW(CW)) u_dbnc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cmp_tick),
        .level     (cmp_level),
        .len       (debounce_len),
        .masked    (mask_on),
        .closed    (loop_closed),
        .irq_start (loop_start_irq),
        .irq_end   (loop_end_irq)
    );

    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_closed) |-> loop_start_irq); // R8

    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_closed) |-> loop_end_irq); // R8

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_start_irq || loop_end_irq) |=> !(loop_start_irq || loop_end_irq)); // R8

    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({loop_start_irq, loop_end_irq}) <= 1); // R8

    AST_STATUS_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmp_tick) |-> $stable(loop_closed)); // R9

endmodule

// File: tb/sim_loop_closure_det.sv
`timescale 1ns/1ps
module sim_loop_closure_det;

    localparam int DW = 16;
    localparam int KW = 15;
    localparam int CW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_stb = 1'b0;
    logic signed [DW-1:0] sample_in = '0;
    logic        [KW-1:0] lpf_coef = 15'h4000;
    logic signed [DW-1:0] thresh_close = 16'sd1000;
    logic signed [DW-1:0] thresh_open = 16'sd500;
    logic        [CW-1:0] debounce_len = 16'd3;
    logic        [CW-1:0] mask_len = 16'd4;
    logic                 ring_burst_end = 1'b0;
    logic                 loop_closed;
    logic                 loop_start_irq;
    logic                 loop_end_irq;

    always #10 clk = ~clk;

    loop_closure_det #(.DW(DW), .KW(KW), .CW(CW)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .sample_stb     (sample_stb),
        .sample_in      (sample_in),
        .lpf_coef       (lpf_coef),
        .thresh_close   (thresh_close),
        .thresh_open    (thresh_open),
        .debounce_len   (debounce_len),
        .mask_len       (mask_len),
        .ring_burst_end (ring_burst_end),
        .loop_closed    (loop_closed),
        .loop_start_irq (loop_start_irq),
        .loop_end_irq   (loop_end_irq)
    );

    typedef struct {
        bit    is_start;
        int    idx;
        string req;
    } ev_t;

    ev_t   sb_q[$];
    int    n_tests = 0;
    int    n_fail = 0;
    int    sidx = 0;
    bit    done = 1'b0;

    task automatic expect_ev(input bit is_start, input int idx, input string req);
        ev_t e;
        e.is_start = is_start;
        e.idx      = idx;
        e.req      = req;
        sb_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int x);
        @(negedge clk);
        sample_stb = 1'b1;
        sample_in  = DW'(x);
        sidx++;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ring();
        @(negedge clk);
        ring_burst_end = 1'b1;
        @(negedge clk);
        ring_burst_end = 1'b0;
    endtask

    // Monitor: pops expected events as interrupt pulses appear.
    always @(negedge clk) begin
        if (rst_n && (loop_start_irq || loop_end_irq)) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8 unexpected irq", sidx, -1);
            end else begin
                ev_t e;
                e = sb_q.pop_front();
                check(loop_start_irq == e.is_start && loop_end_irq == !e.is_start,
                      e.req, int'(loop_start_irq), int'(e.is_start));
                check(sidx == e.idx, e.req, sidx, e.idx);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(loop_closed == 1'b0, "R10 status in reset", int'(loop_closed), 0);
        check(loop_start_irq == 1'b0 && loop_end_irq == 1'b0, "R10 irqs in reset",
              int'(loop_start_irq) + int'(loop_end_irq), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(loop_closed == 1'b0, "R10 status after reset", int'(loop_closed), 0);

        // R5/R6: reversal restarts count, closure after 3 consecutive (idx 6)
        expect_ev(1'b1, 6, "R6 start after reversal");
        send(2000); send(2000); send(0);
        send(2000); send(2000);
        check(loop_closed == 1'b0, "R5 not yet closed", int'(loop_closed), 0);
        send(2000);
        check(loop_closed == 1'b1, "R5 closed after interval", int'(loop_closed), 1);

        // R4: between thresholds holds closed
        for (int i = 0; i < 5; i++) send(700);
        check(loop_closed == 1'b1, "R4 hysteresis holds", int'(loop_closed), 1);
        expect_ev(1'b0, 14, "R4 release below open threshold");
        for (int i = 0; i < 3; i++) send(400);
        check(loop_closed == 1'b0, "R4 released", int'(loop_closed), 0);

        // R3: 700 is not above close threshold
        for (int i = 0; i < 4; i++) send(700);
        check(loop_closed == 1'b0, "R3 below close threshold", int'(loop_closed), 0);

        // R7: mask of 4 samples delays closure to idx 25
        expect_ev(1'b1, 25, "R7 closure after mask");
        pulse_ring();
        for (int i = 0; i < 4; i++) send(2000);
        check(loop_closed == 1'b0, "R7 masked samples ignored", int'(loop_closed), 0);
        for (int i = 0; i < 3; i++) send(2000);

        // R7: comparator frozen high while masked, no release
        pulse_ring();
        for (int i = 0; i < 4; i++) send(0);
        for (int i = 0; i < 3; i++) send(2000);
        check(loop_closed == 1'b1, "R7 mask holds comparator", int'(loop_closed), 1);

        // R5: interval 1 gives an immediate release (idx 33)
        debounce_len = 16'd1;
        expect_ev(1'b0, 33, "R5 interval one");
        send(0);

        // R1/R2: half coefficient step reaches 937 on 4th sample (idx 37)
        lpf_coef     = 15'h2000;
        thresh_close = 16'sd900;
        expect_ev(1'b1, 37, "R1 filtered step crossing");
        for (int i = 0; i < 3; i++) send(1000);
        check(loop_closed == 1'b0, "R1 filter still below", int'(loop_closed), 0);
        send(1000);

        // R2: zero coefficient freezes filter
        lpf_coef = 15'h0000;
        for (int i = 0; i < 3; i++) send(0);
        check(loop_closed == 1'b1, "R2 zero coef freezes", int'(loop_closed), 1);

        // R2: saturated coefficient passes input (idx 41)
        lpf_coef = 15'h7FFF;
        expect_ev(1'b0, 41, "R2 saturated coef");
        send(0);
        check(loop_closed == 1'b0, "R2 saturated coef passes", int'(loop_closed), 0);

        repeat (10) @(negedge clk);
        check(sb_q.size() == 0, "R8 all events seen", sb_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule